// File: doc/BRIEF.md
# Write-Order Hazard Scoreboard for Split Pipes

This block sits in the decode stage of an in-order core whose pipeline forks after operand read into execution pipes of unequal depth, here a one-cycle ALU pipe and an eight-cycle divide pipe. Without a guard, a quick instruction issued after a slow one to the same destination register would write back first, and the older, slow result would then overwrite the newer value.

For every architectural register except register 0, the block holds a countdown of the cycles left before that register's pending write lands. When a decode-stage instruction arrives, the block compares the latency of its target pipe with the countdown of its destination. It holds the instruction in decode while its own write would land no later than the pending one. An accepted instruction loads its register's countdown with its pipe latency. All countdowns tick down once per clock. The mask of registers with writes in flight is brought out for the writeback side.

Top module: `waw_scoreboard`

## Requirements
- R1: Once reset has been released, no register shows a pending write and the stall output is low.
- R2: An instruction with in_valid high, stall low and a nonzero destination is accepted, and pend_mask shows that destination in the next cycle.
- R3: An accepted instruction keeps its destination pending for exactly its pipe latency in cycles: 1 cycle when in_unit is 0 (ALU pipe) and 8 cycles when in_unit is 1 (divide pipe). After that, the bit clears unless the register is written again.
- R4: The stall output is high whenever in_valid is high, the destination is nonzero and pending, and the new pipe latency is less than or equal to the remaining cycles of that pending write.
- R5: No stall is raised when the new pipe latency is greater than the remaining cycles of the pending write to the same register. The instruction is accepted and the countdown restarts from the new latency.
- R6: Destination register 0 never becomes pending and never causes a stall.
- R7: A stalled instruction leaves the table unchanged. The pending write it collided with keeps counting down and clears on its original schedule.
- R8: When an accepted instruction targets a register whose countdown expires in the same cycle, the new write wins. The register stays pending for the new latency.
- R9: While in_valid is low, stall is low and no entry is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Decode stage holds an instruction that writes a register |
| in_unit | input | 1 | Target pipe: 0 = ALU pipe, 1 = divide pipe |
| in_rd | input | 5 | Destination register number |
| stall | output | 1 | Hold the decode-stage instruction this cycle |
| pend_mask | output | 32 | One bit per register with a write still in flight |

## Verification
The bench aims at the boundary where the new latency equals the remaining count. A strict less-than comparison would let a back-to-back divide, or an ALU write after a one-cycle-old ALU write, pass without a stall. It also goes after the cycle where an expiring entry meets a fresh issue to the same register. If clear took priority over set, that register would drop from pend_mask, and a later fast write could then overtake the slow one. A stall that leaked into the table would reload the countdown and stretch the stall. Tracking register 0 would produce phantom stalls. A long random run against a cycle model catches off-by-one countdowns, which show up as pend_mask bits clearing one cycle early or late.

// File: rtl/waw_pkg.sv
package waw_pkg;
  typedef enum logic {
    UNIT_ALU = 1'b0,
    UNIT_DIV = 1'b1
  } unit_e;
endpackage

// File: rtl/waw_lat_lookup.sv
module waw_lat_lookup #(
  parameter int unsigned LAT_ALU = 1,
  parameter int unsigned LAT_DIV = 8,
  parameter int unsigned CNT_W   = 4
) (
  input  logic             unit_sel,
  output logic [CNT_W-1:0] lat
);
  import waw_pkg::*;

  always_comb begin
    if (unit_e'(unit_sel) == UNIT_DIV) lat = CNT_W'(LAT_DIV);
    else                               lat = CNT_W'(LAT_ALU);
  end
endmodule

// File: rtl/waw_entry.sv
module waw_entry #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [CNT_W-1:0] set_cnt,
  output logic             pend,
  output logic [CNT_W-1:0] remain
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // a new issue overrides the tick, including the final tick to zero
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = set_en | (cnt_q != '0);
    if (set_en)              cnt_d = set_cnt;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pend   = (cnt_q != '0);
  assign remain = cnt_q;
endmodule

// File: rtl/waw_clash.sv
module waw_clash #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned REG_W    = 5,
  parameter int unsigned CNT_W    = 4
) (
  input  logic                      in_valid,
  input  logic [REG_W-1:0]          in_rd,
  input  logic [CNT_W-1:0]          new_lat,
  input  logic [NUM_REGS-1:0]       pend_vec,
  input  logic [NUM_REGS*CNT_W-1:0] remain_vec,
  output logic                      clash
);
  logic [CNT_W-1:0] remain_sel;
  logic             hit;

  always_comb begin
    remain_sel = remain_vec[int'(in_rd)*CNT_W +: CNT_W];
    hit        = pend_vec[in_rd] && (in_rd != '0);
    clash      = in_valid && hit && (new_lat <= remain_sel);
  end
endmodule

// File: rtl/waw_scoreboard.sv
module waw_scoreboard #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned LAT_ALU  = 1,
  parameter int unsigned LAT_DIV  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic                        in_unit,
  input  logic [$clog2(NUM_REGS)-1:0] in_rd,
  output logic                        stall,
  output logic [NUM_REGS-1:0]         pend_mask
);
  localparam int unsigned REG_W   = $clog2(NUM_REGS);
  localparam int unsigned MAX_LAT = (LAT_ALU > LAT_DIV) ? LAT_ALU : LAT_DIV;
  localparam int unsigned CNT_W   = $clog2(MAX_LAT + 1);

  logic [1:0]                rst_pipe;
  logic                      rst_sync_n;
  logic [CNT_W-1:0]          new_lat;
  logic [NUM_REGS-1:0]       pend_vec;
  logic [NUM_REGS*CNT_W-1:0] remain_vec;
  logic                      accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  waw_lat_lookup #(.LAT_ALU(LAT_ALU), .LAT_DIV(LAT_DIV), .CNT_W(CNT_W)) lat_i (
    .unit_sel (in_unit),
    .lat      (new_lat)
  );

  waw_clash #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .CNT_W(CNT_W)) clash_i (
    .in_valid   (in_valid),
    .in_rd      (in_rd),
    .new_lat    (new_lat),
    .pend_vec   (pend_vec),
    .remain_vec (remain_vec),
    .clash      (stall)
  );

  assign accept = in_valid && !stall && (in_rd != '0);

  // register 0 is hard-wired idle
  assign pend_vec[0]          = 1'b0;
  assign remain_vec[CNT_W-1:0] = '0;

  for (genvar r = 1; r < NUM_REGS; r++) begin : g_entry
    waw_entry #(.CNT_W(CNT_W)) entry_i (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .set_en  (accept && (in_rd == REG_W'(r))),
      .set_cnt (new_lat),
      .pend    (pend_vec[r]),
      .remain  (remain_vec[r*CNT_W +: CNT_W])
    );
  end

  assign pend_mask = pend_vec;
endmodule

// File: rtl/waw_scoreboard_chk.sv
module waw_scoreboard_chk #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned REG_W    = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [REG_W-1:0]    in_rd,
  input logic                stall,
  input logic [NUM_REGS-1:0] pend_mask
);
  assert_r0_never_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_rd == '0) |-> !stall);

  assert_accept_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !stall && in_rd != '0) |=> pend_mask[$past(in_rd)]);

  assert_idle_no_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !stall);

  assert_stall_needs_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> pend_mask[in_rd]);

  assert_free_reg_no_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !pend_mask[in_rd]) |-> !stall);
endmodule

bind waw_scoreboard waw_scoreboard_chk #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .in_rd     (in_rd),
  .stall     (stall),
  .pend_mask (pend_mask)
);

// File: tb/waw_scoreboard_tb.sv
module waw_scoreboard_tb_top;
  localparam int CLK_P    = 10;
  localparam int NUM_REGS = 32;
  localparam int REG_W    = 5;
  localparam int LAT_ALU  = 1;
  localparam int LAT_DIV  = 8;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                in_valid;
  logic                in_unit;
  logic [REG_W-1:0]    in_rd;
  logic                stall;
  logic [NUM_REGS-1:0] pend_mask;

  int m_cnt [NUM_REGS];
  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  waw_scoreboard #(.NUM_REGS(NUM_REGS), .LAT_ALU(LAT_ALU), .LAT_DIV(LAT_DIV)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_unit   (in_unit),
    .in_rd     (in_rd),
    .stall     (stall),
    .pend_mask (pend_mask)
  );

  function automatic int lat_of(logic u);
    return u ? LAT_DIV : LAT_ALU;
  endfunction

  function automatic logic exp_stall(logic v, logic u, int rd);
    return v && (rd != 0) && (m_cnt[rd] != 0) && (lat_of(u) <= m_cnt[rd]);
  endfunction

  function automatic logic [NUM_REGS-1:0] exp_pend();
    logic [NUM_REGS-1:0] m;
    for (int r = 0; r < NUM_REGS; r++) m[r] = (m_cnt[r] != 0);
    return m;
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic v, logic u, int rd, string tag);
    logic es;
    logic acc;
    @(negedge clk);
    in_valid = v;
    in_unit  = u;
    in_rd    = REG_W'(rd);
    #1;
    es = exp_stall(v, u, rd);
    check(tag, "stall", 64'(stall), 64'(es));
    check(tag, "pend_mask", 64'(pend_mask), 64'(exp_pend()));
    acc = v && !es && (rd != 0);
    @(posedge clk);
    for (int r = 0; r < NUM_REGS; r++) if (m_cnt[r] > 0) m_cnt[r]--;
    if (acc) m_cnt[rd] = lat_of(u);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int r = 0; r < NUM_REGS; r++) m_cnt[r] = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_unit = 1'b0; in_rd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: clean state after reset
    step(1'b1, 1'b0, 3, "R1");
    idle(2, "R1");
    // R6: register 0 ignored for both pipes
    step(1'b1, 1'b1, 0, "R6");
    step(1'b1, 1'b0, 0, "R6");
    idle(1, "R6");
    // R2, R3: divide write lasts 8 cycles, ALU write 1 cycle
    step(1'b1, 1'b1, 5, "R2");
    idle(10, "R3");
    step(1'b1, 1'b0, 6, "R2");
    idle(3, "R3");
    // R4, R7: ALU behind divide to same reg stalls until the divide lands
    step(1'b1, 1'b1, 7, "R4");
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 7, "R7");
    idle(2, "R7");
    // R4: equal latency boundary, divide behind divide
    step(1'b1, 1'b1, 9, "R4");
    step(1'b1, 1'b1, 9, "R4");
    step(1'b1, 1'b1, 9, "R5");
    idle(10, "R5");
    // R8: divide issue meets expiring ALU entry on the same register
    step(1'b1, 1'b0, 8, "R8");
    step(1'b1, 1'b1, 8, "R8");
    idle(10, "R8");
    // R5: ALU then ALU one cycle later to same register is accepted after stall
    step(1'b1, 1'b0, 10, "R5");
    step(1'b1, 1'b0, 10, "R4");
    step(1'b1, 1'b0, 10, "R5");
    idle(2, "R5");
    // R9: invalid instruction sets nothing
    step(1'b0, 1'b1, 11, "R9");
    idle(2, "R9");

    // random mix, mostly on a few registers to provoke clashes
    for (int i = 0; i < 3000; i++) begin
      logic v;
      logic u;
      int   rd;
      v  = ($urandom % 10) < 8;
      u  = $urandom % 2;
      rd = $urandom % 6;
      step(v, u, rd, "R4");
    end
    idle(10, "R3");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule